// File: doc/BRIEF.md
# NAND ECC Result Sequencer

This block runs a chain of parity accumulations over the data beats of a NAND transfer and files each finished parity word in its own numbered result slot. Software programs the chip-select to watch, the data unit width, two segment lengths, a per-slot choice between those lengths, the slot to start in, and then arms the block. Each matching beat is folded into a running column/row parity. When the beat count reaches the length chosen for the current slot, the parity goes into that slot and the pointer advances. After slot 9 is filled the pointer stops at 10 and the block disarms itself.

A typical use covers a page as eight equal segments, plus one short segment over the spare area. The short segment is selected through the length choice of slot 9. The finished results are read through a slot-indexed read port. The pointer and enable read back so that software can see progress.

Top module: `necc_seq`

## Requirements
- R1: Nine result slots, numbered 1 to 9, are read on `rd_data` through `rd_sel`. Any `rd_sel` of 0 or above 9 reads as zero.
- R2: The pointer is 1 after reset. A configuration write stores `cfg_ptr` when its value is from 1 to 10. A value of 0 or above 10 is stored as 1. `ptr_o` shows the pointer at all times.
- R3: When a segment completes, its parity is written into the slot named by the pointer, and the pointer then increments by one in the same edge.
- R4: Completing slot 9 sets the pointer to 10 and clears `en_o`. Beats after that change nothing. A write that arms the block with a pointer of 10 leaves `en_o` at 0.
- R5: A configuration write with `cfg_clr` at 1 zeroes the accumulator, the beat counter and all nine slots. The clear is a pulse, and no clear state is held.
- R6: Bit j-1 of `cfg_size_sel` selects the length of slot j: 0 picks `cfg_size0` units and 1 picks `cfg_size1` units. Lengths must be even, from 2 to 512.
- R7: With `cfg_wide` at 0 each unit is `beat_data[7:0]`, and the upper byte is ignored. With `cfg_wide` at 1 each unit is all 16 bits.
- R8: A beat is counted only when `beat_valid` is 1, `beat_cs` equals the programmed chip-select, and the block is armed. All other cycles change no state.
- R9: A result is {row, column}. The column (bits 15:0) is the XOR of all units in the segment. The row (bits 24:16) is the XOR of the zero-based positions of the units that hold an odd number of ones.
- R10: While `en_o` is 1, configuration writes have no effect, including the clear.
- R11: On the edge that completes a segment, the accumulator and the beat counter return to zero, so the next beat starts a fresh segment.
- R12: After reset `en_o` is 0, the pointer is 1 and every slot reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cs | input | CS_W | Chip-select to watch |
| cfg_wide | input | 1 | 1 selects 16-bit units, 0 selects 8-bit units |
| cfg_size0 | input | SIZE_W | Segment length choice 0 |
| cfg_size1 | input | SIZE_W | Segment length choice 1 |
| cfg_size_sel | input | 9 | Per-slot length select, bit j-1 for slot j |
| cfg_ptr | input | 4 | Starting slot |
| cfg_en | input | 1 | Arm the block |
| cfg_clr | input | 1 | Clear pulse for accumulator and slots |
| beat_valid | input | 1 | Data beat present |
| beat_cs | input | CS_W | Chip-select tag of the beat |
| beat_data | input | DATA_W | Beat payload |
| rd_sel | input | 4 | Slot number to read |
| rd_data | output | SIZE_W+DATA_W-1 | Content of the selected slot |
| ptr_o | output | 4 | Current pointer |
| en_o | output | 1 | Armed flag |

## Verification
The bench builds the block with its defaults: 16-bit data, a 3-bit chip-select and 10-bit length fields. Those defaults make the largest legal length of 512 reachable, and one run drives a full 512-unit segment. That run fills the 9-bit row parity and takes the beat counter to its top value. The vector runs also cover each unit width, mixed length selections, and starting pointers of 1, 4 and 9. Beats for other chip-selects and idle cycles are interleaved throughout, so the ignore rules are tested on every run.

// File: rtl/necc_pkg.sv
package necc_pkg;
  localparam int unsigned NUM_RES = 9;
  localparam int unsigned PTR_W   = 4;
  localparam logic [PTR_W-1:0] PTR_FIRST = PTR_W'(1);
  localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(NUM_RES);
  localparam logic [PTR_W-1:0] PTR_DONE  = PTR_W'(NUM_RES + 1);
endpackage

// File: rtl/necc_rst_sync.sv
module necc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/necc_parity.sv
module necc_parity #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ROW_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step,
  input  logic                    last,
  input  logic                    wide,
  input  logic [DATA_W-1:0]       data,
  input  logic [ROW_W-1:0]        idx,
  output logic [ROW_W+DATA_W-1:0] sum
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] unit, col_q, col_n, col_d;
  logic [ROW_W-1:0]  row_q, row_n, row_d;

  assign unit  = wide ? data : {{(DATA_W-HALF_W){1'b0}}, data[HALF_W-1:0]};
  assign col_n = col_q ^ unit;
  assign row_n = row_q ^ ((^unit) ? idx : '0);
  assign sum   = {row_n, col_n};

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (clr || (step && last)) begin
      col_d = '0;
      row_d = '0;
    end else if (step) begin
      col_d = col_n;
      row_d = row_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (col_q == '0 && row_q == '0)); // R11
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !step) |=> (col_q == '0 && row_q == '0)); // R5
endmodule

// File: rtl/necc_beat_ctr.sv
module necc_beat_ctr #(
  parameter int unsigned SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              sel_big,
  input  logic [SIZE_W-1:0] size0,
  input  logic [SIZE_W-1:0] size1,
  output logic [SIZE_W-2:0] idx,
  output logic              last
);
  logic [SIZE_W-1:0] size_cur, cnt_q, cnt_d;

  assign size_cur = sel_big ? size1 : size0;
  assign last     = (cnt_q == size_cur - 1'b1);
  assign idx      = cnt_q[SIZE_W-2:0];

  always_comb begin
    cnt_d = cnt_q;
    if (clr || (step && last)) cnt_d = '0;
    else if (step)             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (size_cur >= SIZE_W'(2) && !size_cur[0]) |-> (cnt_q < size_cur)); // R6
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/necc_result_bank.sv
module necc_result_bank
  import necc_pkg::*;
#(
  parameter int unsigned RES_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [PTR_W-1:0] wptr,
  input  logic [RES_W-1:0] wdata,
  input  logic [PTR_W-1:0] rsel,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] slot_q [NUM_RES];

  for (genvar j = 1; j <= NUM_RES; j++) begin : g_slot
    logic             hit;
    logic [RES_W-1:0] slot_d;

    assign hit = we && (wptr == PTR_W'(j));

    always_comb begin
      slot_d = slot_q[j-1];
      if (clr)      slot_d = '0;
      else if (hit) slot_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[j-1] <= '0;
      else        slot_q[j-1] <= slot_d;
    end

    AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (slot_q[j-1] == '0)); // R5
  end

  always_comb begin
    rdata = '0;
    for (int j = 1; j <= NUM_RES; j++)
      if (rsel == PTR_W'(j)) rdata = slot_q[j-1];
  end
endmodule

// File: rtl/necc_seq.sv
module necc_seq
  import necc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_W   = 3,
  parameter int unsigned SIZE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CS_W-1:0]          cfg_cs,
  input  logic                     cfg_wide,
  input  logic [SIZE_W-1:0]        cfg_size0,
  input  logic [SIZE_W-1:0]        cfg_size1,
  input  logic [8:0]               cfg_size_sel,
  input  logic [3:0]               cfg_ptr,
  input  logic                     cfg_en,
  input  logic                     cfg_clr,
  input  logic                     beat_valid,
  input  logic [CS_W-1:0]          beat_cs,
  input  logic [DATA_W-1:0]        beat_data,
  input  logic [3:0]               rd_sel,
  output logic [SIZE_W+DATA_W-2:0] rd_data,
  output logic [3:0]               ptr_o,
  output logic                     en_o
);
  localparam int unsigned ROW_W = SIZE_W - 1;
  localparam int unsigned RES_W = ROW_W + DATA_W;

  logic               rst_n_s;
  logic [CS_W-1:0]    cs_q;
  logic               wide_q;
  logic [SIZE_W-1:0]  size0_q, size1_q;
  logic [NUM_RES-1:0] sel_q;
  logic [PTR_W-1:0]   ptr_q, ptr_d, ptr_wr;
  logic               en_q, en_d;
  logic               busy, cfg_take, clr_hit, accept, seg_done, sel_big, last;
  logic [ROW_W-1:0]   idx;
  logic [RES_W-1:0]   sum;

  necc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign busy     = en_q && (ptr_q < PTR_DONE);
  assign cfg_take = cfg_we && !busy;
  assign clr_hit  = cfg_take && cfg_clr;
  assign accept   = busy && beat_valid && (beat_cs == cs_q);
  assign seg_done = accept && last;
  assign ptr_wr   = (cfg_ptr == '0 || cfg_ptr > PTR_DONE) ? PTR_FIRST : cfg_ptr;

  always_comb begin
    sel_big = 1'b0;
    for (int j = 1; j <= NUM_RES; j++)
      if (ptr_q == PTR_W'(j)) sel_big = sel_q[j-1];
  end

  always_comb begin
    ptr_d = ptr_q;
    en_d  = en_q;
    if (cfg_take) begin
      ptr_d = ptr_wr;
      en_d  = cfg_en && (ptr_wr != PTR_DONE);
    end else if (seg_done) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == PTR_LAST) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ptr_q <= PTR_FIRST;
      en_q  <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      en_q  <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_q    <= '0;
      wide_q  <= 1'b0;
      size0_q <= SIZE_W'(2);
      size1_q <= SIZE_W'(2);
      sel_q   <= '0;
    end else if (cfg_take) begin
      cs_q    <= cfg_cs;
      wide_q  <= cfg_wide;
      size0_q <= cfg_size0;
      size1_q <= cfg_size1;
      sel_q   <= cfg_size_sel;
    end
  end

  necc_beat_ctr #(.SIZE_W(SIZE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .clr(clr_hit), .step(accept),
    .sel_big(sel_big), .size0(size0_q), .size1(size1_q),
    .idx(idx), .last(last)
  );

  necc_parity #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_par (
    .clk(clk), .rst_n(rst_n_s), .clr(clr_hit), .step(accept), .last(last),
    .wide(wide_q), .data(beat_data), .idx(idx), .sum(sum)
  );

  necc_result_bank #(.RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .clr(clr_hit), .we(seg_done),
    .wptr(ptr_q), .wdata(sum), .rsel(rd_sel), .rdata(rd_data)
  );

  assign ptr_o = ptr_q;
  assign en_o  = en_q;

  AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ptr_q >= PTR_FIRST && ptr_q <= PTR_DONE)); // R2
  AST_EN_BELOW_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    en_q |-> (ptr_q < PTR_DONE)); // R4
  AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seg_done && ptr_q == PTR_LAST) |=> (ptr_q == PTR_DONE && !en_q)); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> ($stable(cs_q) && $stable(wide_q) && $stable(size0_q) &&
              $stable(size1_q) && $stable(sel_q))); // R10
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !cfg_we) |=> ($stable(ptr_q) && $stable(en_q))); // R8
endmodule

// File: tb/necc_seq_test.sv
module necc_seq_test;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CS_W   = 3;
  localparam int unsigned SIZE_W = 10;
  localparam int unsigned RES_W  = SIZE_W - 1 + DATA_W;
  localparam logic [CS_W-1:0] CS = 3'd5;

  typedef struct packed {
    logic        wide;
    logic [9:0]  s0;
    logic [9:0]  s1;
    logic [8:0]  sel;
    logic [3:0]  p0;
    logic [15:0] seed;
    logic [9:0]  beats;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 10'd4, 10'd2,   9'h100, 4'd1, 16'hA5C3, 10'd34},
    '{1'b1, 10'd6, 10'd8,   9'h0AA, 4'd1, 16'h3C7E, 10'd62},
    '{1'b0, 10'd2, 10'd512, 9'h100, 4'd9, 16'h91F0, 10'd512},
    '{1'b1, 10'd2, 10'd10,  9'h018, 4'd4, 16'h0F5A, 10'd28}
  };

  logic clk, rst_n;
  logic cfg_we, cfg_wide, cfg_en, cfg_clr, beat_valid;
  logic [CS_W-1:0] cfg_cs, beat_cs;
  logic [SIZE_W-1:0] cfg_size0, cfg_size1;
  logic [8:0] cfg_size_sel;
  logic [3:0] cfg_ptr, rd_sel, ptr_o;
  logic [DATA_W-1:0] beat_data;
  logic [RES_W-1:0] rd_data;
  logic en_o;

  int n_chk, n_fail, cyc;
  bit done;
  logic [RES_W-1:0] exp_res [1:9];

  necc_seq #(.DATA_W(DATA_W), .CS_W(CS_W), .SIZE_W(SIZE_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs),
    .cfg_wide(cfg_wide), .cfg_size0(cfg_size0), .cfg_size1(cfg_size1),
    .cfg_size_sel(cfg_size_sel), .cfg_ptr(cfg_ptr), .cfg_en(cfg_en),
    .cfg_clr(cfg_clr), .beat_valid(beat_valid), .beat_cs(beat_cs),
    .beat_data(beat_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ptr_o(ptr_o), .en_o(en_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [CS_W-1:0] c, input logic w,
                           input logic [9:0] s0, input logic [9:0] s1,
                           input logic [8:0] sel, input logic [3:0] p,
                           input logic en, input logic clr);
    cfg_we = 1'b1; cfg_cs = c; cfg_wide = w; cfg_size0 = s0; cfg_size1 = s1;
    cfg_size_sel = sel; cfg_ptr = p; cfg_en = en; cfg_clr = clr;
    @(negedge clk);
    cfg_we = 1'b0; cfg_clr = 1'b0; cfg_en = 1'b0;
  endtask

  task automatic send_beat(input logic [CS_W-1:0] c, input logic [15:0] d);
    beat_valid = 1'b1; beat_cs = c; beat_data = d;
    @(negedge clk);
    beat_valid = 1'b0; beat_cs = CS; beat_data = 16'hFFFF;
  endtask

  function automatic logic [15:0] dat(input int k, input logic [15:0] seed);
    return seed ^ 16'(k * 40503) ^ 16'(k << 7);
  endfunction

  task automatic read_slot(input logic [3:0] j, output logic [RES_W-1:0] v);
    rd_sel = j;
    #1;
    v = rd_data;
  endtask

  initial begin
    logic [RES_W-1:0] rv;
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    cfg_we = 0; cfg_cs = '0; cfg_wide = 0; cfg_size0 = 10'd2; cfg_size1 = 10'd2;
    cfg_size_sel = '0; cfg_ptr = 4'd1; cfg_en = 0; cfg_clr = 0;
    beat_valid = 0; beat_cs = CS; beat_data = '0; rd_sel = 4'd1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check("R12 en after reset", 32'(en_o), 32'd0);
    check("R12 ptr after reset", 32'(ptr_o), 32'd1);
    read_slot(4'd5, rv);
    check("R12 slot5 after reset", 32'(rv), 32'd0);

    // R2 pointer write rules
    cfg_write(CS, 1'b0, 10'd2, 10'd2, 9'h0, 4'd0, 1'b0, 1'b0);
    check("R2 ptr write 0", 32'(ptr_o), 32'd1);
    cfg_write(CS, 1'b0, 10'd2, 10'd2, 9'h0, 4'd7, 1'b0, 1'b0);
    check("R2 ptr write 7", 32'(ptr_o), 32'd7);
    cfg_write(CS, 1'b0, 10'd2, 10'd2, 9'h0, 4'd12, 1'b0, 1'b0);
    check("R2 ptr write 12", 32'(ptr_o), 32'd1);
    // R4 arming with pointer 10
    cfg_write(CS, 1'b0, 10'd2, 10'd2, 9'h0, 4'd10, 1'b1, 1'b0);
    check("R4 ptr 10 kept", 32'(ptr_o), 32'd10);
    check("R4 arm at 10 refused", 32'(en_o), 32'd0);

    // vector walk
    for (int v = 0; v < 4; v++) begin
      vec_t t;
      int k;
      t = VECS[v];
      cfg_write(CS, t.wide, t.s0, t.s1, t.sel, 4'd1, 1'b0, 1'b1);
      cfg_write(CS, t.wide, t.s0, t.s1, t.sel, t.p0, 1'b1, 1'b0);
      check("R2 start ptr", 32'(ptr_o), 32'(t.p0));
      for (int j = 1; j <= 9; j++) exp_res[j] = '0;
      k = 0;
      for (int j = int'(t.p0); j <= 9; j++) begin
        logic [15:0] col;
        logic [8:0]  row;
        int n;
        col = '0; row = '0;
        n = t.sel[j-1] ? int'(t.s1) : int'(t.s0);
        for (int i = 0; i < n; i++) begin
          logic [15:0] d, u;
          d = dat(k, t.seed);
          if (k % 3 == 0) begin
            send_beat(CS ^ 3'd1, ~d);   // R8 foreign chip-select
            @(negedge clk);             // R8 valid low with matching tag
          end
          if (j == int'(t.p0) && i == 1) begin
            cfg_write(CS ^ 3'd2, ~t.wide, 10'd2, 10'd2, 9'h0, 4'd2, 1'b0, 1'b1);
            check("R10 ptr during run", 32'(ptr_o), 32'(t.p0));
            check("R10 en during run", 32'(en_o), 32'd1);
          end
          if (k == int'(t.beats) - 1) begin
            check("R6 ptr before last beat", 32'(ptr_o), 32'd9);
            check("R6 en before last beat", 32'(en_o), 32'd1);
          end
          send_beat(CS, d);
          u = t.wide ? d : {8'h00, d[7:0]};
          col = col ^ u;
          if (^u) row = row ^ 9'(i);
          k++;
        end
        exp_res[j] = {row, col};
      end
      check("R4 ptr frozen", 32'(ptr_o), 32'd10);
      check("R4 en cleared", 32'(en_o), 32'd0);
      for (int j = 1; j <= 9; j++) begin
        read_slot(4'(j), rv);
        check("R3 R9 R11 slot content", 32'(rv), 32'(exp_res[j]));
      end
      repeat (3) send_beat(CS, 16'h1234);
      check("R4 ptr after extra beats", 32'(ptr_o), 32'd10);
      read_slot(4'd9, rv);
      check("R8 slot9 after extra beats", 32'(rv), 32'(exp_res[9]));
    end

    // R7 upper byte ignored in 8-bit mode
    cfg_write(CS, 1'b0, 10'd2, 10'd2, 9'h0, 4'd9, 1'b1, 1'b1);
    send_beat(CS, 16'hFF01);
    send_beat(CS, 16'h0E03);
    read_slot(4'd9, rv);
    check("R7 narrow unit", 32'(rv), 32'h0000_0002);

    // R1 out-of-range reads
    read_slot(4'd0, rv);
    check("R1 read slot 0", 32'(rv), 32'd0);
    read_slot(4'd13, rv);
    check("R1 read slot 13", 32'(rv), 32'd0);

    // R5 clear while idle
    cfg_write(CS, 1'b1, 10'd2, 10'd2, 9'h0, 4'd1, 1'b1, 1'b0);
    for (int j = 1; j <= 9; j++) begin
      send_beat(CS, 16'h00F1);
      send_beat(CS, 16'h0001);
    end
    read_slot(4'd3, rv);
    check("R5 slot3 before clear", 32'(rv), 32'h0001_00F0);
    cfg_write(CS, 1'b1, 10'd2, 10'd2, 9'h0, 4'd1, 1'b0, 1'b1);
    for (int j = 1; j <= 9; j++) begin
      read_slot(4'(j), rv);
      check("R5 slot cleared", 32'(rv), 32'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule